// File: doc/BRIEF.md
# Value-Predicted Load Violation Detector

This block follows loads whose data was guessed after a cache miss, so that dependent work can run ahead on the guess. Each guessed load is held in a small age-ordered table from the moment the guess is made until the real data comes back. The guess is trusted only when two things hold. First, the returned value must equal the guess. Second, no store from another thread or processor may have touched the same 64-byte line while the load was outstanding. A matching value alone is not enough: a remote write to that line means the early value may have been observed out of order with respect to other threads, so the load must be replayed.

Verdicts leave the table strictly in allocation order. Only the oldest entry may report, and it does so once its data has returned. A commit retires that one entry. A squash names the slot to recover from and discards every younger entry with it, because their results all depend on the failed load. A flush input empties the table without reporting anything.

The allocate port uses a valid/ready handshake. A load is accepted on a clock edge where `alloc_valid` and `alloc_ready` are both high. When the table cannot take a new load, `alloc_ready` goes low and the producer must hold its request. The data-return port and the snoop port are always accepted and have no ready signal. The verdict port has no back-pressure either: each verdict is shown for exactly one cycle.

Top module: `vp_load_guard`

## Requirements
- R1: A load is accepted when `alloc_valid` and `alloc_ready` are both high at a clock edge. `alloc_ready` is low while all 8 slots are occupied, while `flush` is high, and during a squash verdict cycle. A request made while `alloc_ready` is low is dropped and never produces a verdict.
- R2: A returned value (`ret_tag` equal to an outstanding entry's tag) that equals that entry's prediction, with no remote snoop hit, yields a commit verdict: `vd_valid`=1 and `vd_squash`=0. The verdict appears in the cycle after the return edge, provided the entry is oldest.
- R3: A returned value that differs from the prediction yields a squash verdict (`vd_squash`=1).
- R4: A snoop with `snp_remote`=1 and `snp_valid`=1 whose address agrees with an outstanding entry's address in bits [31:6] marks that entry as violated. The entry then gets a squash verdict even if its value matches. Addresses in a different 64-byte line have no effect.
- R5: A snoop with `snp_remote`=0 (a local store) never marks an entry.
- R6: A remote snoop hit and a data return for the same entry at the same clock edge give a squash verdict.
- R7: Only the oldest outstanding entry gives a verdict. A younger entry whose data has already returned waits until every older entry has reported.
- R8: A verdict is valid for one cycle and carries the load's tag (`vd_tag`) and slot (`vd_idx`). Slots are handed out in circular order starting at 0 after reset. A committed slot is free at the next edge.
- R9: After a squash verdict the table is empty, with no verdicts for the younger entries. The next accepted load gets slot 0.
- R10: `flush`=1 at an edge empties the table without any verdict. The next accepted load gets slot 0.
- R11: After reset `vd_valid`=0 and `alloc_ready`=1.
- R12: A data return whose tag matches no outstanding entry, or an entry whose data has already returned, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all entries, no verdicts |
| alloc_valid | input | 1 | New predicted load offered |
| alloc_ready | output | 1 | Table can accept a load |
| alloc_tag | input | 8 | Load tag |
| alloc_addr | input | 32 | Load byte address |
| alloc_pred | input | 32 | Predicted value |
| ret_valid | input | 1 | Real load data returning |
| ret_tag | input | 8 | Tag of returning load |
| ret_data | input | 32 | Real value |
| snp_valid | input | 1 | Observed store or invalidation |
| snp_remote | input | 1 | 1 = from another thread or processor |
| snp_addr | input | 32 | Store byte address |
| vd_valid | output | 1 | Verdict pulse |
| vd_squash | output | 1 | 1 = squash, 0 = commit |
| vd_tag | output | 8 | Tag of the judged load |
| vd_idx | output | 3 | Slot to recover from |

## Verification
The assertions take three things for granted. Tags of outstanding loads are unique. A return never names a load in the same cycle that load is allocated. The producer never offers a load against a low `alloc_ready`, except where the bench deliberately tests that a refused request is dropped. The bench keeps within these limits by giving every load in flight its own tag and always returning data at least one cycle after allocation. The refused request in the full-table test uses a tag that is not in flight.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  typedef enum logic {
    VD_COMMIT = 1'b0,
    VD_SQUASH = 1'b1
  } verdict_e;
endpackage

// File: rtl/vpg_order.sv
module vpg_order #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= bump(tail);
      if (pop)  head <= bump(head);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(ENTRIES));
  a_r1_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> count < CNT_W'(ENTRIES));
  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/vpg_entry.sv
module vpg_entry #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 8,
  parameter int LINE_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_pred,
  input  logic              snp_valid,
  input  logic              snp_remote,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              ret_valid,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic [DATA_W-1:0] ret_data,
  output logic              busy,
  output logic              done,
  output logic              bad,
  output logic [TAG_W-1:0]  tag_o
);
  logic [ADDR_W-1:0] line_q;
  logic [DATA_W-1:0] pred_q;
  logic              snp_hit, ret_hit;

  // line compare ignores the offset bits inside a cache line
  assign snp_hit = busy && snp_valid && snp_remote &&
                   ((snp_addr >> LINE_BITS) == line_q);
  assign ret_hit = busy && !done && ret_valid && (ret_tag == tag_o);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      bad    <= 1'b0;
      tag_o  <= '0;
      line_q <= '0;
      pred_q <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      bad    <= 1'b0;
      tag_o  <= ld_tag;
      line_q <= ld_addr >> LINE_BITS;
      pred_q <= ld_pred;
    end else begin
      if (snp_hit) bad <= 1'b1;
      if (ret_hit) begin
        done <= 1'b1;
        if (ret_data != pred_q) bad <= 1'b1;
      end
    end
  end

  a_r4_remote_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && snp_valid && snp_remote && ((snp_addr >> LINE_BITS) == line_q) && !clr)
    |=> bad);
  a_r3_mismatch_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_hit && (ret_data != pred_q) && !clr) |=> (bad && done));
  a_r5_local_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr && !load && !ret_hit && !(snp_valid && snp_remote)) |=> $stable(bad));
  a_r6_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && ret_hit && !clr) |=> bad);
  a_r12_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done && !clr) |=> (done && $stable(tag_o)));
endmodule

// File: rtl/vp_load_guard.sv
module vp_load_guard #(
  parameter int ENTRIES   = 8,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 8,
  parameter int LINE_BITS = 6,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int CNT_W    = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_pred,
  input  logic              ret_valid,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic [DATA_W-1:0] ret_data,
  input  logic              snp_valid,
  input  logic              snp_remote,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              vd_valid,
  output logic              vd_squash,
  output logic [TAG_W-1:0]  vd_tag,
  output logic [IDX_W-1:0]  vd_idx
);
  import vpg_pkg::*;

  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] occ;
  logic             accept, retire, wipe, full;
  logic [ENTRIES-1:0] busy_v, done_v, bad_v;
  logic [TAG_W-1:0]   tag_v [ENTRIES];
  verdict_e           kind;

  assign full        = (occ == CNT_W'(ENTRIES));
  assign kind        = bad_v[head] ? VD_SQUASH : VD_COMMIT;
  assign vd_valid    = busy_v[head] && done_v[head] && !flush;
  assign vd_squash   = (kind == VD_SQUASH);
  assign vd_tag      = tag_v[head];
  assign vd_idx      = head;
  assign alloc_ready = !full && !flush && !(vd_valid && vd_squash);
  assign accept      = alloc_valid && alloc_ready;
  assign retire      = vd_valid && !vd_squash;
  assign wipe        = flush || (vd_valid && vd_squash);

  vpg_order #(.ENTRIES(ENTRIES)) u_order (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (wipe),
    .push  (accept),
    .pop   (retire),
    .head  (head),
    .tail  (tail),
    .count (occ)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    vpg_entry #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .LINE_BITS(LINE_BITS)
    ) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (wipe || (retire && head == IDX_W'(i))),
      .load       (accept && tail == IDX_W'(i)),
      .ld_tag     (alloc_tag),
      .ld_addr    (alloc_addr),
      .ld_pred    (alloc_pred),
      .snp_valid  (snp_valid),
      .snp_remote (snp_remote),
      .snp_addr   (snp_addr),
      .ret_valid  (ret_valid),
      .ret_tag    (ret_tag),
      .ret_data   (ret_data),
      .busy       (busy_v[i]),
      .done       (done_v[i]),
      .bad        (bad_v[i]),
      .tag_o      (tag_v[i])
    );
  end

  a_r1_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ready);
  a_r8_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
    vd_valid |=> !busy_v[$past(head)]);
  a_r9_squash_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && vd_squash) |=> (occ == '0 && busy_v == '0));
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0 && !vd_valid));
  a_r11_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!vd_valid && alloc_ready));
endmodule

// File: tb/test_vp_load_guard.sv
`timescale 1ns/1ps
module test_vp_load_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [7:0]  alloc_tag = '0;
  logic [31:0] alloc_addr = '0;
  logic [31:0] alloc_pred = '0;
  logic        ret_valid = 1'b0;
  logic [7:0]  ret_tag = '0;
  logic [31:0] ret_data = '0;
  logic        snp_valid = 1'b0;
  logic        snp_remote = 1'b0;
  logic [31:0] snp_addr = '0;
  logic        vd_valid, vd_squash;
  logic [7:0]  vd_tag;
  logic [2:0]  vd_idx;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_idx = 0;

  always #2.5 clk = ~clk;

  vp_load_guard i_vp_load_guard (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .alloc_addr(alloc_addr), .alloc_pred(alloc_pred),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data),
    .snp_valid(snp_valid), .snp_remote(snp_remote), .snp_addr(snp_addr),
    .vd_valid(vd_valid), .vd_squash(vd_squash), .vd_tag(vd_tag), .vd_idx(vd_idx)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [7:0] t, input logic [31:0] a, input logic [31:0] p);
    alloc_valid = 1'b1; alloc_tag = t; alloc_addr = a; alloc_pred = p;
    cyc();
    alloc_valid = 1'b0;
  endtask

  task automatic give(input logic [7:0] t, input logic [31:0] d);
    ret_valid = 1'b1; ret_tag = t; ret_data = d;
    cyc();
    ret_valid = 1'b0;
  endtask

  task automatic spy(input logic [31:0] a, input logic r);
    snp_valid = 1'b1; snp_addr = a; snp_remote = r;
    cyc();
    snp_valid = 1'b0;
  endtask

  task automatic verdict(input string req, input logic sq, input logic [7:0] t, input int idx);
    chk({req, " vd_valid"}, vd_valid, 1);
    chk({req, " vd_squash"}, vd_squash, sq);
    chk({req, " vd_tag"}, vd_tag, t);
    chk({req, " vd_idx"}, vd_idx, idx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired: got running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R11 vd_valid after reset", vd_valid, 0);
    chk("R11 alloc_ready after reset", alloc_ready, 1);

    // sweep: value match/mismatch x snoop kind
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [31:0] a, p;
        logic [7:0]  t;
        logic        sq;
        string       req;
        a = 32'h0000_4000 + 32'((m * 4 + s) * 256);
        p = 32'hA000 + 32'(m * 4 + s);
        t = 8'(20 + m * 4 + s);
        put(t, a, p);
        if (s == 1) spy(a | 32'h3C, 1'b0);
        if (s == 2) spy(a | 32'h25, 1'b1);
        if (s == 3) spy(a + 32'd64, 1'b1);
        give(t, m == 1 ? (p ^ 32'h1) : p);
        sq  = (m == 1) || (s == 2);
        req = (s == 1) ? "R5" : (s == 2) ? "R4" : (m == 1) ? "R3" : "R2";
        verdict($sformatf("%s sweep m%0d s%0d", req, m, s), sq, t, exp_idx);
        exp_idx = sq ? 0 : (exp_idx + 1) % 8;
        cyc();
        chk("R8 single-cycle pulse", vd_valid, 0);
      end
    end

    // R6: snoop and return on the same edge
    put(8'd30, 32'h0000_9000, 32'h55);
    snp_valid = 1'b1; snp_remote = 1'b1; snp_addr = 32'h0000_9010;
    ret_valid = 1'b1; ret_tag = 8'd30; ret_data = 32'h55;
    cyc();
    snp_valid = 1'b0; ret_valid = 1'b0;
    verdict("R6 same edge", 1'b1, 8'd30, exp_idx);
    exp_idx = 0;
    cyc();

    // R7: younger waits for older
    put(8'd40, 32'h100, 32'h1);
    put(8'd41, 32'h200, 32'h2);
    give(8'd41, 32'h2);
    chk("R7 younger held back", vd_valid, 0);
    give(8'd40, 32'h1);
    verdict("R7 older first", 1'b0, 8'd40, 0);
    cyc();
    verdict("R7 younger next", 1'b0, 8'd41, 1);
    cyc();
    chk("R7 nothing left", vd_valid, 0);
    exp_idx = 2;

    // R9: squash discards younger finished entries
    put(8'd50, 32'h300, 32'h3);
    put(8'd51, 32'h400, 32'h4);
    put(8'd52, 32'h500, 32'h5);
    give(8'd51, 32'h4);
    give(8'd52, 32'h5);
    chk("R7 blocked behind 50", vd_valid, 0);
    give(8'd50, 32'h7);
    verdict("R9 squash oldest", 1'b1, 8'd50, exp_idx);
    cyc();
    chk("R9 younger dropped", vd_valid, 0);
    chk("R9 ready after squash", alloc_ready, 1);
    give(8'd51, 32'h4);
    chk("R12 return to dropped tag", vd_valid, 0);
    exp_idx = 0;

    // R1: fill the table
    for (int i = 0; i < 8; i++) put(8'(60 + i), 32'h1000 + 32'(i * 64), 32'(i));
    chk("R1 ready low when full", alloc_ready, 0);
    put(8'd99, 32'h8000, 32'h9);
    chk("R1 refused load no verdict", vd_valid, 0);
    for (int i = 0; i < 8; i++) begin
      give(8'(60 + i), 32'(i));
      verdict($sformatf("R8 in-order slot %0d", i), 1'b0, 8'(60 + i), i);
      if (i == 0) chk("R1 still full during verdict", alloc_ready, 0);
      if (i == 1) chk("R1 ready after free", alloc_ready, 1);
    end
    cyc();
    chk("R8 table drained", vd_valid, 0);
    give(8'd99, 32'h9);
    chk("R12 unknown tag ignored", vd_valid, 0);

    // R10: flush
    put(8'd70, 32'h2000, 32'h70);
    put(8'd71, 32'h3000, 32'h71);
    flush = 1'b1;
    #1;
    chk("R10 ready low in flush", alloc_ready, 0);
    cyc();
    flush = 1'b0;
    give(8'd70, 32'h70);
    chk("R10 flushed entry silent", vd_valid, 0);
    put(8'd72, 32'h4000, 32'h72);
    give(8'd72, 32'h72);
    verdict("R10 slot restarts", 1'b0, 8'd72, 0);
    cyc();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule